// File: doc/BRIEF.md
# Boost Converter Startup and Fault Sequencer

This block is the digital sequencer for a synchronous boost regulator. It takes the regulator from shutdown through two linear precharge phases. The first phase uses a weak current source and the second a stronger one. It then runs a soft-start ramp in which the peak current limit starts at half of full scale and steps up to full scale. After that it enters normal boost operation. It watches a set of digitized comparator flags. From them it declares faults, holds a timed cool-down before retrying, stops switching on over-temperature, and latches off when the output and feedback disagree.

All phase timing is counted on a separate fault-clock tick, a one-cycle strobe from an external divider. Every other decision is taken on any system clock edge. Dropping the enable, or losing the input undervoltage flag, returns the block to shutdown on the next edge, whether or not a tick is present. The analog loop, the pulse timing and the comparators themselves lie outside this block.

Top module: `boost_startup_seq`

## Requirements
- R1: `stateCode` encodes the phases as follows: 0 off, 1 weak precharge, 2 strong precharge, 3 soft-start, 4 boost, 5 fault, 6 thermal hold, 7 latched off. During and after reset the state is off (0), and in the off state `linSel`, `ilimCode`, `swEn`, `rectEn` and `pathEn` are all 0.
- R2: The off state is left for weak precharge only on an edge where both `enIn` and `vinOk` are high. Weak precharge drives `linSel`=1 and `pathEn`=1, with `swEn`=0.
- R3: In weak precharge, `outNearIn` high moves the block to soft-start. If the 16th fault-clock tick in the phase arrives with `outNearIn` still low, the block moves to strong precharge, which drives `linSel`=2.
- R4: In strong precharge, `outNearIn` high moves the block to soft-start. If the 64th tick in the phase arrives with `outNearIn` still low, the block moves to fault.
- R5: In soft-start, `swEn`=1 and `ilimCode` equals 32 plus the number of ticks seen in the phase. The code saturates at full scale, 64, after 32 ticks.
- R6: In soft-start, `outAtTarget` high moves the block to boost, where `ilimCode`=64. If the 96th tick after the ramp reaches full scale arrives without it, the block moves to fault.
- R7: In boost, 32 consecutive ticks with `ilimHit` high move the block to fault. A tick with `ilimHit` low restarts the run.
- R8: In soft-start and boost, `rectEn` is low in the same cycle that `outNearIn` is low. In boost, `outNearIn` low also moves the block to fault on the next edge.
- R9: In fault, `swEn`, `pathEn` and `linSel` are 0. On the 480th tick in the phase the block restarts in weak precharge.
- R10: `overTemp` high moves any precharge, soft-start, boost or fault state to thermal hold, where switching and the path are off. When `overTemp` clears, the block restarts in weak precharge.
- R11: `fbMismatch` high moves any state except off to latched off. The latch ignores `vinOk` and is released to off only by `enIn` low or by `outLow` and `inLow` both high.
- R12: `enIn` low forces off on the next edge from every state. `vinOk` low does the same from every state except latched off. Neither needs a tick.
- R13: Phase timers advance only on cycles where `faultTick` is high. Any number of cycles without a tick leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultTick | input | 1 | One-cycle fault-clock strobe that times the phases |
| enIn | input | 1 | Regulator enable |
| vinOk | input | 1 | Input is above undervoltage lockout |
| outNearIn | input | 1 | Output is within about 1 V of the input |
| outAtTarget | input | 1 | Output has reached 90% of its set point |
| ilimHit | input | 1 | Peak current limit reached in this period |
| overTemp | input | 1 | Over-temperature flag |
| fbMismatch | input | 1 | Output and feedback sense disagree |
| outLow | input | 1 | Output is below its undervoltage level |
| inLow | input | 1 | Input is below its recovery level |
| stateCode | output | 3 | Current phase, encoded as in R1 |
| linSel | output | 2 | Linear source select: 0 off, 1 weak, 2 strong |
| ilimCode | output | 7 | Peak current-limit code; 64 is full scale |
| swEn | output | 1 | Boost switching enable |
| rectEn | output | 1 | Synchronous rectifier enable |
| pathEn | output | 1 | Input-to-output path connected (0 means load disconnected) |

## Verification
A table of precharge scenarios applies `outNearIn` after 0, 15, 16, 79 and 80 ticks. These points separate advancing from the weak phase, the last weak tick, the first strong tick, the last strong tick and the precharge fault. The current-limit persistence is driven with a run broken one tick short of the limit, followed by a full run, which tells a consecutive counter from a cumulative one. The soft-start is checked at entry, mid-ramp, full scale, and on both sides of the hold timeout. The over-temperature, short, cool-down and latch tests each compare the state the block should leave with the state it should reach. The latch test also tries each release condition on its own.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PRE_LO = 3'd1,
    ST_PRE_HI = 3'd2,
    ST_RAMP   = 3'd3,
    ST_RUN    = 3'd4,
    ST_FAULT  = 3'd5,
    ST_HOT    = 3'd6,
    ST_LOCK   = 3'd7
  } seqState_t;

  typedef enum logic [1:0] {
    LIM_PRE_LO = 2'd0,
    LIM_PRE_HI = 2'd1,
    LIM_HOLD   = 2'd2,
    LIM_COOL   = 2'd3
  } limSel_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic    clear;
    logic    runTimer;
    limSel_t limSel;
    logic    runRamp;
    logic    runPersist;
  } seqStrobe_t;

endpackage

// File: rtl/bss_timers.sv
module bss_timers
  import bss_pkg::*;
#(
  parameter int PRE_LO_TICKS  = 16,
  parameter int PRE_HI_TICKS  = 64,
  parameter int RAMP_TICKS    = 32,
  parameter int HOLD_TICKS    = 96,
  parameter int PERSIST_TICKS = 32,
  parameter int COOL_TICKS    = 480,
  localparam int MAX_A   = (PRE_LO_TICKS > PRE_HI_TICKS) ? PRE_LO_TICKS : PRE_HI_TICKS,
  localparam int MAX_B   = (HOLD_TICKS > COOL_TICKS) ? HOLD_TICKS : COOL_TICKS,
  localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int TMR_W   = $clog2(MAX_LIM),
  localparam int RAMP_W  = $clog2(RAMP_TICKS + 1),
  localparam int PER_W   = $clog2(PERSIST_TICKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultTick,
  input  logic              ilimHit,
  input  seqStrobe_t        strobe,
  output logic              timerExpire,
  output logic              rampDone,
  output logic              persistExpire,
  output logic [RAMP_W-1:0] rampStep
);

  localparam logic [TMR_W-1:0]  LO_LAST   = TMR_W'(PRE_LO_TICKS - 1);
  localparam logic [TMR_W-1:0]  HI_LAST   = TMR_W'(PRE_HI_TICKS - 1);
  localparam logic [TMR_W-1:0]  HOLD_LAST = TMR_W'(HOLD_TICKS - 1);
  localparam logic [TMR_W-1:0]  COOL_LAST = TMR_W'(COOL_TICKS - 1);
  localparam logic [RAMP_W-1:0] RAMP_END  = RAMP_W'(RAMP_TICKS);
  localparam logic [PER_W-1:0]  PER_LAST  = PER_W'(PERSIST_TICKS - 1);

  logic [TMR_W-1:0]  phaseTimer;
  logic [TMR_W-1:0]  lastCount;
  logic [RAMP_W-1:0] rampCnt;
  logic [PER_W-1:0]  persistCnt;
  logic              timerStep;
  logic              rampStepEn;
  logic              persistStep;

  always_comb begin
    case (strobe.limSel)
      LIM_PRE_LO: lastCount = LO_LAST;
      LIM_PRE_HI: lastCount = HI_LAST;
      LIM_HOLD:   lastCount = HOLD_LAST;
      default:    lastCount = COOL_LAST;
    endcase
  end

  assign timerStep     = faultTick && strobe.runTimer;
  assign timerExpire   = timerStep && (phaseTimer == lastCount);
  assign rampDone      = (rampCnt == RAMP_END);
  assign rampStepEn    = faultTick && strobe.runRamp && !rampDone;
  assign persistStep   = faultTick && strobe.runPersist;
  assign persistExpire = persistStep && ilimHit && (persistCnt == PER_LAST);
  assign rampStep      = rampCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      phaseTimer <= '0;
    end else if (timerStep && !timerExpire) begin
      phaseTimer <= phaseTimer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      rampCnt <= '0;
    end else if (rampStepEn) begin
      rampCnt <= rampCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      persistCnt <= '0;
    end else if (persistStep) begin
      if (!ilimHit) begin
        persistCnt <= '0;
      end else if (!persistExpire) begin
        persistCnt <= persistCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enIn,
  input  logic       vinOk,
  input  logic       outNearIn,
  input  logic       outAtTarget,
  input  logic       overTemp,
  input  logic       fbMismatch,
  input  logic       outLow,
  input  logic       inLow,
  input  logic       timerExpire,
  input  logic       rampDone,
  input  logic       persistExpire,
  output seqState_t  state,
  output seqStrobe_t strobe
);

  seqState_t stateQ;
  seqState_t stateNext;
  seqState_t phaseNext;

  // phase progression without the global overrides
  always_comb begin
    phaseNext = stateQ;
    case (stateQ)
      ST_OFF:    if (enIn && vinOk) phaseNext = ST_PRE_LO;
      ST_PRE_LO: if (outNearIn) phaseNext = ST_RAMP;
                 else if (timerExpire) phaseNext = ST_PRE_HI;
      ST_PRE_HI: if (outNearIn) phaseNext = ST_RAMP;
                 else if (timerExpire) phaseNext = ST_FAULT;
      ST_RAMP:   if (outAtTarget) phaseNext = ST_RUN;
                 else if (timerExpire) phaseNext = ST_FAULT;
      ST_RUN:    if (!outNearIn || persistExpire) phaseNext = ST_FAULT;
      ST_FAULT:  if (timerExpire) phaseNext = ST_PRE_LO;
      ST_HOT:    if (!overTemp) phaseNext = ST_PRE_LO;
      ST_LOCK:   if (outLow && inLow) phaseNext = ST_OFF;
      default:   phaseNext = ST_OFF;
    endcase
  end

  // overrides, lowest priority first
  always_comb begin
    stateNext = phaseNext;
    if (overTemp && stateQ != ST_OFF && stateQ != ST_LOCK && stateQ != ST_HOT) begin
      stateNext = ST_HOT;
    end
    if (fbMismatch && stateQ != ST_OFF && stateQ != ST_LOCK) begin
      stateNext = ST_LOCK;
    end
    if (!enIn) begin
      stateNext = ST_OFF;
    end else if (!vinOk && stateQ != ST_LOCK) begin
      stateNext = ST_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe.clear      = (stateNext != stateQ);
    strobe.runTimer   = (stateQ == ST_PRE_LO) || (stateQ == ST_PRE_HI) ||
                        (stateQ == ST_FAULT) || (stateQ == ST_RAMP && rampDone);
    strobe.runRamp    = (stateQ == ST_RAMP);
    strobe.runPersist = (stateQ == ST_RUN);
    case (stateQ)
      ST_PRE_HI: strobe.limSel = LIM_PRE_HI;
      ST_RAMP:   strobe.limSel = LIM_HOLD;
      ST_FAULT:  strobe.limSel = LIM_COOL;
      default:   strobe.limSel = LIM_PRE_LO;
    endcase
  end

  assign state = stateQ;

endmodule

// File: rtl/boost_startup_seq.sv
module boost_startup_seq
  import bss_pkg::*;
#(
  parameter int PRE_LO_TICKS  = 16,
  parameter int PRE_HI_TICKS  = 64,
  parameter int RAMP_TICKS    = 32,
  parameter int HOLD_TICKS    = 96,
  parameter int PERSIST_TICKS = 32,
  parameter int COOL_TICKS    = 480,
  localparam int ILIM_W = $clog2(2 * RAMP_TICKS + 1),
  localparam int RAMP_W = $clog2(RAMP_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultTick,
  input  logic              enIn,
  input  logic              vinOk,
  input  logic              outNearIn,
  input  logic              outAtTarget,
  input  logic              ilimHit,
  input  logic              overTemp,
  input  logic              fbMismatch,
  input  logic              outLow,
  input  logic              inLow,
  output logic [2:0]        stateCode,
  output logic [1:0]        linSel,
  output logic [ILIM_W-1:0] ilimCode,
  output logic              swEn,
  output logic              rectEn,
  output logic              pathEn
);

  localparam logic [ILIM_W-1:0] HALF_CODE = ILIM_W'(RAMP_TICKS);
  localparam logic [ILIM_W-1:0] FULL_CODE = ILIM_W'(2 * RAMP_TICKS);

  seqState_t         state;
  seqStrobe_t        strobe;
  logic              timerExpire;
  logic              rampDone;
  logic              persistExpire;
  logic [RAMP_W-1:0] rampStep;

  bss_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enIn          (enIn),
    .vinOk         (vinOk),
    .outNearIn     (outNearIn),
    .outAtTarget   (outAtTarget),
    .overTemp      (overTemp),
    .fbMismatch    (fbMismatch),
    .outLow        (outLow),
    .inLow         (inLow),
    .timerExpire   (timerExpire),
    .rampDone      (rampDone),
    .persistExpire (persistExpire),
    .state         (state),
    .strobe        (strobe)
  );

  bss_timers #(
    .PRE_LO_TICKS  (PRE_LO_TICKS),
    .PRE_HI_TICKS  (PRE_HI_TICKS),
    .RAMP_TICKS    (RAMP_TICKS),
    .HOLD_TICKS    (HOLD_TICKS),
    .PERSIST_TICKS (PERSIST_TICKS),
    .COOL_TICKS    (COOL_TICKS)
  ) u_timers (
    .clk           (clk),
    .rstN          (rstN),
    .faultTick     (faultTick),
    .ilimHit       (ilimHit),
    .strobe        (strobe),
    .timerExpire   (timerExpire),
    .rampDone      (rampDone),
    .persistExpire (persistExpire),
    .rampStep      (rampStep)
  );

  always_comb begin
    stateCode = state;
    swEn      = (state == ST_RAMP) || (state == ST_RUN);
    // rectifier drops in the same cycle the output collapses
    rectEn    = swEn && outNearIn;
    pathEn    = swEn || (state == ST_PRE_LO) || (state == ST_PRE_HI);
    case (state)
      ST_PRE_LO: linSel = 2'd1;
      ST_PRE_HI: linSel = 2'd2;
      default:   linSel = 2'd0;
    endcase
    case (state)
      ST_RAMP: ilimCode = HALF_CODE + ILIM_W'(rampStep);
      ST_RUN:  ilimCode = FULL_CODE;
      default: ilimCode = '0;
    endcase
  end

endmodule

// File: rtl/bss_checker.sv
module bss_checker
  import bss_pkg::*;
#(
  parameter int RAMP_TICKS = 32,
  localparam int ILIM_W = $clog2(2 * RAMP_TICKS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultTick,
  input logic              enIn,
  input logic              vinOk,
  input logic              outNearIn,
  input logic              overTemp,
  input logic              fbMismatch,
  input logic              outLow,
  input logic              inLow,
  input logic [2:0]        stateCode,
  input logic [1:0]        linSel,
  input logic [ILIM_W-1:0] ilimCode,
  input logic              swEn,
  input logic              rectEn,
  input logic              pathEn
);

  localparam logic [ILIM_W-1:0] HALF = ILIM_W'(RAMP_TICKS);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_OFF) |-> (!swEn && !pathEn && !rectEn && linSel == 2'd0 && ilimCode == '0));

  p_sw_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    swEn |-> (stateCode == ST_RAMP || stateCode == ST_RUN));

  p_ramp_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_RAMP && $past(stateCode) != ST_RAMP) |-> (ilimCode == HALF));

  p_rect_short_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outNearIn |-> !rectEn);

  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_FAULT) |-> (!swEn && !pathEn && linSel == 2'd0));

  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_LOCK && enIn && !(outLow && inLow)) |=> (stateCode == ST_LOCK));

  p_en_drop_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (stateCode == ST_OFF));

  p_no_tick_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_PRE_LO && !faultTick && enIn && vinOk && !outNearIn &&
     !overTemp && !fbMismatch) |=> (stateCode == ST_PRE_LO));

endmodule

bind boost_startup_seq bss_checker #(.RAMP_TICKS(RAMP_TICKS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .faultTick  (faultTick),
  .enIn       (enIn),
  .vinOk      (vinOk),
  .outNearIn  (outNearIn),
  .overTemp   (overTemp),
  .fbMismatch (fbMismatch),
  .outLow     (outLow),
  .inLow      (inLow),
  .stateCode  (stateCode),
  .linSel     (linSel),
  .ilimCode   (ilimCode),
  .swEn       (swEn),
  .rectEn     (rectEn),
  .pathEn     (pathEn)
);

// File: tb/tb_boost_startup_seq.sv
module tb_boost_startup_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       faultTick = 1'b0;
  logic       enIn = 1'b0;
  logic       vinOk = 1'b1;
  logic       outNearIn = 1'b0;
  logic       outAtTarget = 1'b0;
  logic       ilimHit = 1'b0;
  logic       overTemp = 1'b0;
  logic       fbMismatch = 1'b0;
  logic       outLow = 1'b0;
  logic       inLow = 1'b0;
  logic [2:0] stateCode;
  logic [1:0] linSel;
  logic [6:0] ilimCode;
  logic       swEn;
  logic       rectEn;
  logic       pathEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  boost_startup_seq dut (
    .clk(clk), .rstN(rstN), .faultTick(faultTick), .enIn(enIn), .vinOk(vinOk),
    .outNearIn(outNearIn), .outAtTarget(outAtTarget), .ilimHit(ilimHit),
    .overTemp(overTemp), .fbMismatch(fbMismatch), .outLow(outLow), .inLow(inLow),
    .stateCode(stateCode), .linSel(linSel), .ilimCode(ilimCode), .swEn(swEn),
    .rectEn(rectEn), .pathEn(pathEn)
  );

  // precharge scenarios: ticks before the output comes near the input, expected state
  typedef struct packed {
    logic [7:0] delay;
    logic [2:0] expState;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'd0,  3'd3},
    '{8'd15, 3'd3},
    '{8'd16, 3'd3},
    '{8'd79, 3'd3},
    '{8'd80, 3'd5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; tick is high only across this edge
  task automatic cyc(input logic t);
    faultTick = t;
    @(posedge clk);
    #2;
    faultTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic quiet();
    enIn = 1'b0; vinOk = 1'b1; outNearIn = 1'b0; outAtTarget = 1'b0;
    ilimHit = 1'b0; overTemp = 1'b0; fbMismatch = 1'b0; outLow = 1'b0; inLow = 1'b0;
    cyc(1'b0);
  endtask

  task automatic goRun();
    quiet();
    enIn = 1'b1;
    cyc(1'b0);
    outNearIn = 1'b1;
    cyc(1'b0);
    outAtTarget = 1'b1;
    cyc(1'b0);
    outAtTarget = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset state", stateCode, 0);
    chk("R1 reset outputs", {linSel, ilimCode, swEn, rectEn, pathEn}, 0);
    rstN = 1'b1;
    cyc(1'b0);
    chk("R1 off after reset", stateCode, 0);

    // R2: enable without input above lockout stays off
    enIn = 1'b1; vinOk = 1'b0;
    cyc(1'b0);
    chk("R2 held off by lockout", stateCode, 0);
    vinOk = 1'b1;
    cyc(1'b0);
    chk("R2 weak precharge", stateCode, 1);
    chk("R2 weak source", linSel, 1);
    chk("R2 path on switch off", {pathEn, swEn}, 2);

    // R13: no ticks, no progress; then 16th tick leaves weak precharge
    for (int i = 0; i < 40; i++) cyc(1'b0);
    chk("R13 no tick hold", stateCode, 1);
    ticks(15);
    chk("R3 15 ticks still weak", stateCode, 1);
    ticks(1);
    chk("R3 16th tick strong", stateCode, 2);
    chk("R3 strong source", linSel, 2);

    // table of precharge scenarios (R3, R4)
    foreach (VECS[k]) begin
      int d;
      int expLin;
      d = int'(VECS[k].delay);
      quiet();
      enIn = 1'b1;
      cyc(1'b0);
      ticks(d);
      expLin = (d < 16) ? 1 : ((d < 80) ? 2 : 0);
      chk("R3 R4 source level before near", linSel, expLin);
      outNearIn = 1'b1;
      cyc(1'b0);
      chk("R3 R4 state after near", stateCode, int'(VECS[k].expState));
    end

    // R5 and R6: soft-start ramp and hold timeout
    quiet();
    enIn = 1'b1;
    cyc(1'b0);
    outNearIn = 1'b1;
    cyc(1'b0);
    chk("R5 soft-start entry", stateCode, 3);
    chk("R5 half code", ilimCode, 32);
    chk("R5 switching on", swEn, 1);
    ticks(10);
    chk("R5 mid ramp", ilimCode, 42);
    ticks(22);
    chk("R5 full scale", ilimCode, 64);
    ticks(10);
    chk("R5 saturated", ilimCode, 64);
    ticks(85);
    chk("R6 95 hold ticks", stateCode, 3);
    ticks(1);
    chk("R6 hold timeout fault", stateCode, 5);

    // R6: reaching target enters boost at full scale
    goRun();
    chk("R6 boost entry", stateCode, 4);
    chk("R6 boost full code", ilimCode, 64);

    // R7: persistence filter
    ilimHit = 1'b1;
    ticks(31);
    ilimHit = 1'b0;
    ticks(1);
    ilimHit = 1'b1;
    ticks(31);
    chk("R7 broken run no fault", stateCode, 4);
    ticks(1);
    chk("R7 32 consecutive fault", stateCode, 5);

    // R8: short in boost, then R9 cool-down
    goRun();
    outNearIn = 1'b0;
    #1;
    chk("R8 rectifier off same cycle", rectEn, 0);
    chk("R8 still boost", stateCode, 4);
    cyc(1'b0);
    chk("R8 short fault", stateCode, 5);
    chk("R9 fault outputs", {swEn, pathEn, linSel}, 0);
    ticks(479);
    chk("R9 479 ticks still fault", stateCode, 5);
    ticks(1);
    chk("R9 restart weak precharge", stateCode, 1);

    // R10: over-temperature
    goRun();
    overTemp = 1'b1;
    cyc(1'b0);
    chk("R10 thermal hold", stateCode, 6);
    chk("R10 switch and path off", {swEn, pathEn}, 0);
    ticks(5);
    chk("R10 stays hot", stateCode, 6);
    overTemp = 1'b0;
    cyc(1'b0);
    chk("R10 restart weak precharge", stateCode, 1);

    // R11: latch and its release conditions
    goRun();
    fbMismatch = 1'b1;
    cyc(1'b0);
    chk("R11 latched", stateCode, 7);
    fbMismatch = 1'b0;
    vinOk = 1'b0;
    cyc(1'b0);
    chk("R11 lockout ignored", stateCode, 7);
    chk("R11 path off", {pathEn, swEn}, 0);
    outLow = 1'b1;
    cyc(1'b0);
    chk("R11 output low alone", stateCode, 7);
    inLow = 1'b1; vinOk = 1'b1;
    cyc(1'b0);
    chk("R11 both low release", stateCode, 0);
    goRun();
    fbMismatch = 1'b1;
    cyc(1'b0);
    fbMismatch = 1'b0;
    enIn = 1'b0;
    cyc(1'b0);
    chk("R11 enable release", stateCode, 0);

    // R12: enable drop and lockout from boost, no tick
    goRun();
    enIn = 1'b0;
    cyc(1'b0);
    chk("R12 enable drop off", stateCode, 0);
    chk("R12 outputs quiet", {linSel, ilimCode, swEn, rectEn, pathEn}, 0);
    goRun();
    vinOk = 1'b0;
    cyc(1'b0);
    chk("R12 lockout off", stateCode, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule